// File: doc/BRIEF.md
# Serial Configuration Memory Emulator

This block stands in for a serial configuration memory that an external configuration master reads one bit at a time. Several design images ("revisions") are stored side by side in a computed on-chip array, each in a region of the same size. The master drives a slow configuration clock. Every rising edge of that clock moves the read pointer on by one bit, and the addressed bit is presented on a single serial data output whose driver can be switched off.

The readout is gated by three conditions. The first is an active-low chip enable. The second is a shared open-drain reset line, which either side may pull low. The third is a mode-select input that enables serial mode. When any of them is off, the data and clock-out drivers are disabled and the read pointer returns to the start of the region. After the block's own reset, the block pulls the shared line low for a fixed number of internal clock cycles and then lets it go. The revision to read is taken from two select pins when an active-low select enable is low, and from a default otherwise. The revision is captured while the readout is held and stays frozen during the read.

All master-side inputs pass through a two-stage synchronizer on the free-running internal clock. The configuration clock edge is detected in that domain, so the data output follows a master clock edge after a few internal cycles.

Top module: `scfg_emu`

## Requirements
- R1: After `rst_n` rises, `rst_pull_low_o` stays 1 and goes to 0 exactly POR_CYCLES internal clock edges later, counting the first edge after reset as one. It never rises again until the next `rst_n` assertion.
- R2: While the shared reset line (`rst_line_i`) reads low, including during the power-on hold and when it is pulled low externally, `data_oe_o` and `clk_out_oe_o` are 0. Once the line returns high, readout restarts at bit 0 of the region.
- R3: While `ce_n_i` is 1, `data_oe_o` and `clk_out_oe_o` are 0. Taking `ce_n_i` high in the middle of a read and low again restarts the readout at bit 0 of the selected region.
- R4: While `mode_sel_i` is 0, both output enables are 0 and configuration clock edges do not move the read pointer. Readout starts at bit 0 once the mode returns to 1.
- R5: Each rising edge of `cfg_clk_i` advances the read pointer by exactly one bit. Bits of each stored byte leave most significant bit first, byte 0 first.
- R6: With `ext_sel_n_i` = 0, `rev_sel_i` selects revision r. Its region starts at bit r × REGION_BYTES × 8. Byte i of revision r holds (r·64 XOR i·29 XOR 0xA5) mod 256.
- R7: With `ext_sel_n_i` = 1, revision DEFAULT_REV (0 by default) is read, whatever `rev_sel_i` holds.
- R8: The revision is captured only while readout is held. Changing `rev_sel_i` or `ext_sel_n_i` during an active read has no effect on the data.
- R9: After the last bit of the selected region has been passed, `data_o` reads 1 on every further clock edge. The pointer never moves into the next region.
- R10: While the outputs are enabled, `clk_out_o` follows the level of `cfg_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst_n | input | 1 | Active-low block reset, starts the power-on sequence |
| cfg_clk_i | input | 1 | Configuration clock from the master |
| ce_n_i | input | 1 | Active-low chip enable |
| rst_line_i | input | 1 | Sampled level of the shared open-drain reset line |
| rst_pull_low_o | output | 1 | 1 = drive the shared reset line low |
| mode_sel_i | input | 1 | 1 = serial mode selected |
| ext_sel_n_i | input | 1 | Active-low enable for the revision-select pins |
| rev_sel_i | input | REV_SEL_W | Revision index |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | Driver enable for data_o (0 = high impedance) |
| clk_out_o | output | 1 | Clock-out level |
| clk_out_oe_o | output | 1 | Driver enable for clk_out_o |

## Verification
The hardest state to reach is a read interrupted partway through a region, with a different revision requested on the select pins. That case shows whether the pointer restarts and whether the captured revision holds. The stimulus reads a few bytes of one revision, changes `rev_sel_i` mid-read, and then pulses chip enable, or pulls the shared line low through the bench's wired-AND model. After each step it reads on, and a scoreboard compares every bit against the stored pattern. It also runs past the end of the first and the last region to confirm that the output parks at 1 instead of running into the following image.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    // Read sequencer states
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_e;

    // Content of byte idx of revision rev
    function automatic logic [7:0] pattern_byte(input int unsigned rev, input int unsigned idx);
        logic [31:0] v;
        v = (rev * 32'd64) ^ (idx * 32'd29) ^ 32'hA5;
        return v[7:0];
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int unsigned     W         = 4,
    parameter int unsigned     STAGES    = 2,
    parameter logic [W-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_i;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RESET_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/scfg_por.sv
module scfg_por #(
    parameter int unsigned POR_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pull_low_o,
    output logic por_done_o
);
    localparam int unsigned CW = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } por_regs_t;

    por_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt != CW'(POR_CYCLES)) nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign por_done_o = (cur_q.cnt == CW'(POR_CYCLES));
    assign pull_low_o = !por_done_o;

    // R1
    por_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_low_o |=> !pull_low_o);
endmodule

// File: rtl/scfg_rom.sv
module scfg_rom
    import scfg_pkg::*;
#(
    parameter int unsigned NUM_REV      = 4,
    parameter int unsigned REGION_BYTES = 16,
    parameter int unsigned AW           = 10
) (
    input  logic [AW-1:0] bit_addr_i,
    output logic          bit_o
);
    localparam int unsigned TOTAL = NUM_REV * REGION_BYTES;

    logic [7:0]    rom_w [TOTAL];
    logic [AW-4:0] byte_idx;
    logic [2:0]    bit_sel;

    generate
        for (genvar g = 0; g < int'(TOTAL); g++) begin : g_byte
            assign rom_w[g] = pattern_byte(g / REGION_BYTES, g % REGION_BYTES);
        end
    endgenerate

    assign byte_idx = bit_addr_i[AW-1:3];
    assign bit_sel  = ~bit_addr_i[2:0];

    always_comb begin
        bit_o = 1'b1;
        if (int'(byte_idx) < int'(TOTAL)) bit_o = rom_w[byte_idx][bit_sel];
    end
endmodule

// File: rtl/scfg_reader.sv
module scfg_reader
    import scfg_pkg::*;
#(
    parameter int unsigned REV_SEL_W    = 2,
    parameter int unsigned REGION_BYTES = 16,
    parameter int unsigned DEFAULT_REV  = 0,
    parameter int unsigned AW           = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active_i,
    input  logic                 cfg_rise_i,
    input  logic                 ext_sel_n_i,
    input  logic [REV_SEL_W-1:0] rev_sel_i,
    input  logic                 rom_bit_i,
    output logic [AW-1:0]        rd_addr_o,
    output logic                 data_o,
    output logic                 data_oe_o
);
    localparam int unsigned REGION_BITS = REGION_BYTES * 8;
    localparam int unsigned BIW         = $clog2(REGION_BITS + 1);
    localparam logic [REV_SEL_W-1:0] DEF_REV = REV_SEL_W'(DEFAULT_REV);

    typedef struct packed {
        rd_state_e            state;
        logic [BIW-1:0]       bit_idx;
        logic [REV_SEL_W-1:0] rev;
        logic                 data;
        logic                 oe;
    } rd_regs_t;

    rd_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!active_i) begin
            nxt_d.state   = RD_IDLE;
            nxt_d.bit_idx = '0;
            nxt_d.rev     = ext_sel_n_i ? DEF_REV : rev_sel_i;
            nxt_d.oe      = 1'b0;
        end else begin
            nxt_d.oe = 1'b1;
            unique case (cur_q.state)
                RD_IDLE: nxt_d.state = RD_SHIFT;
                RD_SHIFT: begin
                    if (cfg_rise_i) begin
                        nxt_d.bit_idx = cur_q.bit_idx + 1'b1;
                        if (cur_q.bit_idx == BIW'(REGION_BITS - 1)) nxt_d.state = RD_DONE;
                    end
                end
                RD_DONE: nxt_d.state = RD_DONE;
                default: nxt_d.state = RD_IDLE;
            endcase
        end
        nxt_d.data = (cur_q.state == RD_DONE) ? 1'b1 : rom_bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.state   <= RD_IDLE;
            cur_q.rev     <= DEF_REV;
            cur_q.data    <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_addr_o = AW'(cur_q.rev) * AW'(REGION_BITS) + AW'(cur_q.bit_idx);
    assign data_o    = cur_q.data;
    assign data_oe_o = cur_q.oe;

    // R3
    hiz_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !data_oe_o);

    // R5
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i)) |->
            ((cur_q.bit_idx == $past(cur_q.bit_idx)) ||
             (cur_q.bit_idx == BIW'($past(cur_q.bit_idx) + 1'b1))));

    // R8
    rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i)) |-> $stable(cur_q.rev));

    // R9
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.bit_idx <= BIW'(REGION_BITS));
endmodule

// File: rtl/scfg_emu.sv
module scfg_emu #(
    parameter int unsigned REV_SEL_W    = 2,
    parameter int unsigned REGION_BYTES = 16,
    parameter int unsigned POR_CYCLES   = 100000,
    parameter int unsigned DEFAULT_REV  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_clk_i,
    input  logic                 ce_n_i,
    input  logic                 rst_line_i,
    output logic                 rst_pull_low_o,
    input  logic                 mode_sel_i,
    input  logic                 ext_sel_n_i,
    input  logic [REV_SEL_W-1:0] rev_sel_i,
    output logic                 data_o,
    output logic                 data_oe_o,
    output logic                 clk_out_o,
    output logic                 clk_out_oe_o
);
    localparam int unsigned NUM_REV    = 2 ** REV_SEL_W;
    localparam int unsigned TOTAL_BITS = NUM_REV * REGION_BYTES * 8;
    localparam int unsigned AW         = $clog2(TOTAL_BITS + 1);

    typedef struct packed {
        logic cfg_prev;
        logic clk_out;
    } top_regs_t;

    top_regs_t cur_q, nxt_d;

    logic [3:0]    sync_w;
    logic          cfg_s, ce_n_s, line_s, mode_s;
    logic          por_done, cfg_rise, active;
    logic [AW-1:0] rd_addr;
    logic          rom_bit;

    scfg_sync #(.W(4), .STAGES(2), .RESET_VAL(4'b0100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cfg_clk_i, ce_n_i, rst_line_i, mode_sel_i}),
        .sync_o  (sync_w)
    );

    assign cfg_s  = sync_w[3];
    assign ce_n_s = sync_w[2];
    assign line_s = sync_w[1];
    assign mode_s = sync_w[0];

    scfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk        (clk),
        .rst_n      (rst_n),
        .pull_low_o (rst_pull_low_o),
        .por_done_o (por_done)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.cfg_prev = cfg_s;
        nxt_d.clk_out  = cfg_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cfg_rise = cfg_s && !cur_q.cfg_prev;
    assign active   = por_done && line_s && !ce_n_s && mode_s;

    scfg_reader #(
        .REV_SEL_W    (REV_SEL_W),
        .REGION_BYTES (REGION_BYTES),
        .DEFAULT_REV  (DEFAULT_REV),
        .AW           (AW)
    ) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .cfg_rise_i  (cfg_rise),
        .ext_sel_n_i (ext_sel_n_i),
        .rev_sel_i   (rev_sel_i),
        .rom_bit_i   (rom_bit),
        .rd_addr_o   (rd_addr),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o)
    );

    scfg_rom #(
        .NUM_REV      (NUM_REV),
        .REGION_BYTES (REGION_BYTES),
        .AW           (AW)
    ) u_rom (
        .bit_addr_i (rd_addr),
        .bit_o      (rom_bit)
    );

    assign clk_out_o    = cur_q.clk_out;
    assign clk_out_oe_o = data_oe_o;

    // R2
    line_low_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_s |=> !data_oe_o);

    // R4
    mode_off_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |=> (!data_oe_o && !clk_out_oe_o));
endmodule

// File: tb/scfg_emu_tb.sv
module scfg_emu_tb;
    localparam int POR = 40;
    localparam int RB  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_clk = 1'b0, ce_n = 1'b1, mode_sel = 1'b1, ext_sel_n = 1'b0, ext_hold = 1'b0;
    logic [1:0] rev_sel = 2'd0;
    logic rst_pull_low, data, data_oe, clk_out, clk_out_oe, rst_line;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    logic  exp_q[$];
    string tag_q[$];
    event  smp_ev;

    always #2.5 clk = ~clk;

    // wired-AND of the open-drain line
    assign rst_line = !(rst_pull_low || ext_hold);

    scfg_emu #(.REV_SEL_W(2), .REGION_BYTES(RB), .POR_CYCLES(POR), .DEFAULT_REV(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_clk_i(cfg_clk), .ce_n_i(ce_n),
        .rst_line_i(rst_line), .rst_pull_low_o(rst_pull_low), .mode_sel_i(mode_sel),
        .ext_sel_n_i(ext_sel_n), .rev_sel_i(rev_sel), .data_o(data), .data_oe_o(data_oe),
        .clk_out_o(clk_out), .clk_out_oe_o(clk_out_oe)
    );

    function automatic logic [7:0] exp_byte(input int r, input int i);
        int v;
        v = (r * 64) ^ (i * 29) ^ 165;
        return v[7:0];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse();
        cfg_clk = 1'b1;
        repeat (8) @(negedge clk);
        cfg_clk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // driver: push expected bit, request sample, then clock the pointer on
    task automatic read_bit(input logic b, input string tag);
        @(negedge clk);
        exp_q.push_back(b);
        tag_q.push_back(tag);
        -> smp_ev;
        #0.1;
        pulse();
    endtask

    task automatic read_rev(input int r, input int start, input int nbits, input string tag);
        for (int n = start; n < start + nbits; n++) begin
            logic [7:0] b;
            b = exp_byte(r, n / 8);
            read_bit(b[7 - (n % 8)], tag);
        end
    endtask

    // monitor: pop expected bit and compare with the serial output
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " oe"}, int'(data_oe), 1);
                chk({t, " data"}, int'(data), int'(e));
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 reset pull", int'(rst_pull_low), 1);
        chk("R2 reset oe", int'(data_oe), 0);
        ce_n = 1'b0;
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) chk("R2 por hold oe", int'(data_oe), 0);
        end while (rst_pull_low && n < 1000);
        chk("R1 por length", n, POR);
        settle();
        chk("R3 enabled oe", int'(data_oe), 1);
        chk("R10 clkout oe", int'(clk_out_oe), 1);

        // R5 R6: full revision 0, then R9 end hold
        read_rev(0, 0, RB * 8, "R5");
        read_bit(1'b1, "R9");
        read_bit(1'b1, "R9");

        // R10 clock-out follows cfg clock
        cfg_clk = 1'b1; settle();
        chk("R10 clkout high", int'(clk_out), 1);
        cfg_clk = 1'b0; settle();
        chk("R10 clkout low", int'(clk_out), 0);

        // R3 standby, select revision 2
        ce_n = 1'b1; settle();
        chk("R3 standby oe", int'(data_oe), 0);
        chk("R3 standby clk oe", int'(clk_out_oe), 0);
        rev_sel = 2'd2;
        ce_n = 1'b0; settle();
        read_rev(2, 0, 20, "R6");
        ce_n = 1'b1; settle();
        chk("R3 mid-read oe", int'(data_oe), 0);
        ce_n = 1'b0; settle();
        read_rev(2, 0, 8, "R3");

        // R8 change selection during read
        rev_sel = 2'd1;
        ext_sel_n = 1'b1;
        settle();
        read_rev(2, 8, 16, "R8");
        ext_sel_n = 1'b0;

        // R2 external low on the shared line
        ext_hold = 1'b1; settle();
        chk("R2 ext low oe", int'(data_oe), 0);
        chk("R2 ext low clk oe", int'(clk_out_oe), 0);
        ext_hold = 1'b0; settle();
        read_rev(1, 0, 16, "R2");

        // R7 select pins disabled
        ext_sel_n = 1'b1;
        rev_sel = 2'd3;
        ce_n = 1'b1; settle();
        ce_n = 1'b0; settle();
        read_rev(0, 0, 16, "R7");

        // R4 mode off
        mode_sel = 1'b0; settle();
        chk("R4 mode off oe", int'(data_oe), 0);
        chk("R4 mode off clk oe", int'(clk_out_oe), 0);
        pulse(); pulse();
        mode_sel = 1'b1; settle();
        read_rev(0, 0, 8, "R4");

        // R9 last revision, no wrap
        ext_sel_n = 1'b0;
        ce_n = 1'b1; settle();
        ce_n = 1'b0; settle();
        read_rev(3, 0, RB * 8, "R6");
        read_bit(1'b1, "R9");
        read_bit(1'b1, "R9");
        read_bit(1'b1, "R9");

        settle();
        done = 1'b1;
        finish_up();
    end
endmodule